// File: doc/BRIEF.md
# Page operation sequencer

This block carries out the self-timed operations that touch the main page array of a serial page-organised memory, once a command front end has decoded them. It holds a small array of pages and two page-sized buffers. It runs five operations, each for a fixed number of clock cycles: page-to-buffer transfer, page-to-buffer compare, buffer-to-page program with erase, buffer-to-page program without erase, and auto page rewrite. While one runs, the block reports busy on a flag and on an open-drain pull-down enable.

Only one array operation runs at a time. A second array command that arrives while busy is dropped and flagged. The buffer that the running operation does not use stays open for byte reads and writes. A write-protect input blocks programming of the lowest pages. An active-low asynchronous reset aborts the running operation.

The durations are parameters, and so are the array and buffer sizes and the protected range. Whole-page data moves in one cycle, at the end of the busy interval.

Top module: `page_seq`

## Requirements
- R1: After reset is released, busy_o, rb_pull_low_o and err_o are all 0.
- R2: Op code 2 (program with erase) is accepted when idle. busy_o is 1 from the accepting edge for exactly T_EP cycles. When it falls, every byte of the page equals the chosen buffer.
- R3: Op code 3 (program without erase) keeps busy_o high for exactly T_PROG cycles. Each byte of the page then becomes its old value ANDed with the buffer byte.
- R4: Op code 0 (transfer) keeps busy_o high for exactly T_XFR cycles. The chosen buffer then holds a copy of the page.
- R5: Op code 1 (compare) keeps busy_o high for T_XFR cycles. When busy_o falls, cmp_diff_o becomes 0 if every bit of the page equals the buffer, and 1 if any bit differs, including a single bit in the last byte. At all other times cmp_diff_o holds its value.
- R6: Op code 4 (auto rewrite) keeps busy_o high for T_XFR+T_EP cycles. It copies the page into the chosen buffer and then programs that buffer back into the same page with erase.
- R7: A command with op code 0 to 4 that arrives while busy_o is 1 is dropped. err_o is then 1 for the one cycle after that edge, and the running operation's duration and result are unchanged.
- R8: While busy_o is 1, byte writes to the buffer not used by the running operation take effect. Byte writes to the buffer in use are ignored.
- R9: While wp_ni is 0, op codes 2, 3 and 4 that name a page below PROT_PAGES do not raise busy_o and leave the page unchanged. Pages at or above PROT_PAGES are still programmed.
- R10: Driving rst_ni low during an operation drops busy_o at once. The target page and cmp_diff_o keep their values from before that operation, and a command issued after release runs normally.
- R11: rb_pull_low_o is 1 exactly while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_ni | input | 1 | Write protect, active low |
| cmd_valid_i | input | 1 | Array command strobe |
| cmd_op_i | input | 3 | Op code: 0 transfer, 1 compare, 2 program with erase, 3 program without erase, 4 rewrite |
| cmd_buf_i | input | 1 | Buffer chosen by the command |
| cmd_page_i | input | PG_AW | Target page |
| buf_we_i | input | 1 | Buffer byte write enable |
| buf_sel_i | input | 1 | Buffer for byte access |
| buf_addr_i | input | BY_AW | Byte offset in buffer |
| buf_wdata_i | input | 8 | Byte write data |
| buf_rdata_o | output | 8 | Byte read data from selected buffer |
| mem_page_i | input | PG_AW | Page for array byte read |
| mem_addr_i | input | BY_AW | Byte offset for array read |
| mem_rdata_o | output | 8 | Array byte read data |
| busy_o | output | 1 | Array operation in progress |
| rb_pull_low_o | output | 1 | Open-drain ready/busy pull-down enable |
| cmp_diff_o | output | 1 | Latched compare result, 1 = mismatch |
| err_o | output | 1 | One-cycle pulse on a dropped command |

## Verification
The bench measures every busy interval against its expected length. A design that restarted the timer on a dropped command, or that ran rewrite as a single phase, would show a wrong count. Program without erase is tested on a page that already holds data, so a design that erased first would leave bits set where the AND clears them. A compare is run whose only difference is one bit in the last byte; a design that stopped one byte short would report a match. Protected requests, writes into the buffer in use, and resets in the middle of a program or compare are each checked against the page or flag they must not change.

// File: rtl/page_seq_pkg.sv
package page_seq_pkg;
  typedef enum logic [2:0] {
    OP_XFR       = 3'd0,
    OP_CMP       = 3'd1,
    OP_PGM_ERASE = 3'd2,
    OP_PGM_AND   = 3'd3,
    OP_REWRITE   = 3'd4
  } page_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RUN
  } seq_st_e;
endpackage

// File: rtl/op_timer.sv
module op_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/page_array.sv
module page_array #(
  parameter int unsigned NUM_PAGES  = 8,
  parameter int unsigned PAGE_BYTES = 16,
  localparam int unsigned PG_AW     = $clog2(NUM_PAGES),
  localparam int unsigned BY_AW     = $clog2(PAGE_BYTES)
) (
  input  logic                          clk_i,
  input  logic                          wr_en_i,
  input  logic                          wr_erase_i,
  input  logic [PG_AW-1:0]              wr_page_i,
  input  logic [PAGE_BYTES-1:0][7:0]    wr_data_i,
  input  logic [PG_AW-1:0]              rd_page_i,
  output logic [PAGE_BYTES-1:0][7:0]    rd_data_o,
  input  logic [PG_AW-1:0]              dbg_page_i,
  input  logic [BY_AW-1:0]              dbg_addr_i,
  output logic [7:0]                    dbg_data_o
);
  logic [PAGE_BYTES-1:0][7:0] mem_q [NUM_PAGES];

  // erase mode overwrites; otherwise bits can only be cleared
  always_ff @(posedge clk_i) begin
    if (wr_en_i)
      mem_q[wr_page_i] <= wr_erase_i ? wr_data_i : (mem_q[wr_page_i] & wr_data_i);
  end

  assign rd_data_o  = mem_q[rd_page_i];
  assign dbg_data_o = mem_q[dbg_page_i][dbg_addr_i];
endmodule

// File: rtl/page_buffers.sv
module page_buffers #(
  parameter int unsigned PAGE_BYTES = 16,
  localparam int unsigned BY_AW     = $clog2(PAGE_BYTES)
) (
  input  logic                       clk_i,
  input  logic                       load_i,
  input  logic                       load_sel_i,
  input  logic [PAGE_BYTES-1:0][7:0] load_data_i,
  input  logic                       we_i,
  input  logic                       wr_sel_i,
  input  logic [BY_AW-1:0]           wr_addr_i,
  input  logic [7:0]                 wr_data_i,
  input  logic                       page_sel_i,
  output logic [PAGE_BYTES-1:0][7:0] page_o,
  input  logic                       rd_sel_i,
  input  logic [BY_AW-1:0]           rd_addr_i,
  output logic [7:0]                 rd_data_o
);
  logic [PAGE_BYTES-1:0][7:0] bufs [2];

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [PAGE_BYTES-1:0][7:0] data_q;
    always_ff @(posedge clk_i) begin
      if (load_i && load_sel_i == 1'(b))
        data_q <= load_data_i;
      else if (we_i && wr_sel_i == 1'(b))
        data_q[wr_addr_i] <= wr_data_i;
    end
    assign bufs[b] = data_q;
  end

  assign page_o    = bufs[page_sel_i];
  assign rd_data_o = bufs[rd_sel_i][rd_addr_i];
endmodule

// File: rtl/page_seq.sv
module page_seq
  import page_seq_pkg::*;
#(
  parameter int unsigned NUM_PAGES  = 8,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned PROT_PAGES = 2,
  parameter int unsigned T_XFR      = 4,
  parameter int unsigned T_PROG     = 8,
  parameter int unsigned T_EP       = 12,
  localparam int unsigned PG_AW     = $clog2(NUM_PAGES),
  localparam int unsigned BY_AW     = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W     = $clog2(T_EP + T_PROG + T_XFR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wp_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic             cmd_buf_i,
  input  logic [PG_AW-1:0] cmd_page_i,
  input  logic             buf_we_i,
  input  logic             buf_sel_i,
  input  logic [BY_AW-1:0] buf_addr_i,
  input  logic [7:0]       buf_wdata_i,
  output logic [7:0]       buf_rdata_o,
  input  logic [PG_AW-1:0] mem_page_i,
  input  logic [BY_AW-1:0] mem_addr_i,
  output logic [7:0]       mem_rdata_o,
  output logic             busy_o,
  output logic             rb_pull_low_o,
  output logic             cmp_diff_o,
  output logic             err_o
);
  localparam logic [PG_AW:0] PROT_LIM = (PG_AW+1)'(PROT_PAGES);

  seq_st_e            st_q;
  page_op_e           op_q, op_in;
  logic               buf_q;
  logic [PG_AW-1:0]   page_q;
  logic               err_q, cmp_q;
  logic               op_ok, is_prog_in, prot_hit, accept, tmr_exp;
  logic               tmr_load, fetch_done, run_done;
  logic [CNT_W-1:0]   tmr_val;
  logic               arr_wr, buf_load, byte_we;
  logic [PAGE_BYTES-1:0][7:0] arr_page, buf_page;

  always_comb begin
    op_in      = page_op_e'(cmd_op_i);
    op_ok      = (cmd_op_i <= 3'd4);
    is_prog_in = op_in inside {OP_PGM_ERASE, OP_PGM_AND, OP_REWRITE};
    prot_hit   = is_prog_in && !wp_ni && ({1'b0, cmd_page_i} < PROT_LIM);
    accept     = cmd_valid_i && op_ok && (st_q == ST_IDLE) && !prot_hit;
    fetch_done = (st_q == ST_FETCH) && tmr_exp;
    run_done   = (st_q == ST_RUN) && tmr_exp;
    tmr_load   = accept || fetch_done;
    unique case (op_in)
      OP_PGM_ERASE: tmr_val = CNT_W'(T_EP - 1);
      OP_PGM_AND:   tmr_val = CNT_W'(T_PROG - 1);
      default:      tmr_val = CNT_W'(T_XFR - 1);
    endcase
    if (fetch_done) tmr_val = CNT_W'(T_EP - 1);
    arr_wr   = run_done && (op_q inside {OP_PGM_ERASE, OP_PGM_AND, OP_REWRITE});
    buf_load = fetch_done || (run_done && op_q == OP_XFR);
    // the buffer owned by a running operation is closed to byte writes
    byte_we  = buf_we_i && !((st_q != ST_IDLE) && (buf_sel_i == buf_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_XFR;
      buf_q  <= 1'b0;
      page_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= cmd_valid_i && op_ok && (st_q != ST_IDLE);
      if (accept) begin
        st_q   <= (op_in == OP_REWRITE) ? ST_FETCH : ST_RUN;
        op_q   <= op_in;
        buf_q  <= cmd_buf_i;
        page_q <= cmd_page_i;
      end else if (fetch_done) begin
        st_q <= ST_RUN;
      end else if (run_done) begin
        st_q <= ST_IDLE;
      end
    end
  end

  // compare flag survives reset on purpose
  always_ff @(posedge clk_i) begin
    if (run_done && op_q == OP_CMP) cmp_q <= (arr_page != buf_page);
  end

  op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  page_array #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk_i      (clk_i),
    .wr_en_i    (arr_wr),
    .wr_erase_i (op_q != OP_PGM_AND),
    .wr_page_i  (page_q),
    .wr_data_i  (buf_page),
    .rd_page_i  (page_q),
    .rd_data_o  (arr_page),
    .dbg_page_i (mem_page_i),
    .dbg_addr_i (mem_addr_i),
    .dbg_data_o (mem_rdata_o)
  );

  page_buffers #(.PAGE_BYTES(PAGE_BYTES)) u_bufs (
    .clk_i       (clk_i),
    .load_i      (buf_load),
    .load_sel_i  (buf_q),
    .load_data_i (arr_page),
    .we_i        (byte_we),
    .wr_sel_i    (buf_sel_i),
    .wr_addr_i   (buf_addr_i),
    .wr_data_i   (buf_wdata_i),
    .page_sel_i  (buf_q),
    .page_o      (buf_page),
    .rd_sel_i    (buf_sel_i),
    .rd_addr_i   (buf_addr_i),
    .rd_data_o   (buf_rdata_o)
  );

  assign busy_o        = (st_q != ST_IDLE);
  assign rb_pull_low_o = (st_q != ST_IDLE);
  assign cmp_diff_o    = cmp_q;
  assign err_o         = err_q;
endmodule

// File: rtl/page_seq_chk.sv
module page_seq_chk #(
  parameter int unsigned NUM_PAGES  = 8,
  parameter int unsigned PROT_PAGES = 2,
  parameter int unsigned T_XFR      = 4,
  parameter int unsigned T_EP       = 12,
  localparam int unsigned PG_AW     = $clog2(NUM_PAGES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wp_ni,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_op_i,
  input logic [PG_AW-1:0] cmd_page_i,
  input logic             busy_o,
  input logic             cmp_diff_o,
  input logic             err_o
);
  logic op_ok, prot;
  logic [15:0] busy_cnt;

  assign op_ok = (cmd_op_i <= 3'd4);
  assign prot  = (cmd_op_i >= 3'd2) && op_ok && !wp_ni && (32'(cmd_page_i) < PROT_PAGES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  a_r7_err_needs_busy_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(busy_o && cmd_valid_i));

  a_r7_busy_cmd_flags_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i && op_ok) |=> err_o);

  a_r2_idle_cmd_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && op_ok && !prot) |=> busy_o);

  a_r9_protected_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && prot) |=> !busy_o);

  a_r5_cmp_only_at_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_o) |-> $stable(cmp_diff_o));

  a_r6_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= 16'(T_XFR + T_EP));
endmodule

bind page_seq page_seq_chk #(
  .NUM_PAGES(NUM_PAGES), .PROT_PAGES(PROT_PAGES), .T_XFR(T_XFR), .T_EP(T_EP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wp_ni(wp_ni), .cmd_valid_i(cmd_valid_i),
  .cmd_op_i(cmd_op_i), .cmd_page_i(cmd_page_i), .busy_o(busy_o),
  .cmp_diff_o(cmp_diff_o), .err_o(err_o)
);

// File: tb/page_seq_bench.sv
module page_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8, PB = 16, PROT = 2;
  localparam int TX = 4, TP = 8, TE = 12;

  logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1;
  logic cmd_valid = 1'b0, cmd_buf = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [2:0] cmd_page = '0;
  logic buf_we = 1'b0, buf_sel = 1'b0;
  logic [3:0] buf_addr = '0, mem_addr = '0;
  logic [7:0] buf_wdata = '0, buf_rdata, mem_rdata;
  logic [2:0] mem_page = '0;
  logic busy, pull_low, cmp_diff, err;

  int checks = 0, errors = 0;
  logic [7:0] m_mem [NP][PB];
  logic [7:0] m_buf [2][PB];
  int exp_len_q[$];
  string exp_tag_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_seq u_page_seq (
    .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_n), .cmd_valid_i(cmd_valid),
    .cmd_op_i(cmd_op), .cmd_buf_i(cmd_buf), .cmd_page_i(cmd_page),
    .buf_we_i(buf_we), .buf_sel_i(buf_sel), .buf_addr_i(buf_addr),
    .buf_wdata_i(buf_wdata), .buf_rdata_o(buf_rdata), .mem_page_i(mem_page),
    .mem_addr_i(mem_addr), .mem_rdata_o(mem_rdata), .busy_o(busy),
    .rb_pull_low_o(pull_low), .cmp_diff_o(cmp_diff), .err_o(err)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: measures each busy interval and pops the expected length
  int run_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) run_cnt = 0;
    else if (busy) run_cnt++;
    else if (run_cnt > 0) begin
      if (exp_len_q.size() == 0) check("busy interval unexpected", run_cnt, 0);
      else check(exp_tag_q.pop_front(), run_cnt, exp_len_q.pop_front());
      run_cnt = 0;
    end
  end

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed * 37 + i * 11 + 5);
  endfunction

  task automatic bwrite(bit b, int a, logic [7:0] d, bit apply);
    @(negedge clk);
    buf_we = 1; buf_sel = b; buf_addr = 4'(a); buf_wdata = d;
    @(negedge clk);
    buf_we = 0;
    if (apply) m_buf[b][a] = d;
  endtask

  task automatic fill(bit b, int seed);
    for (int i = 0; i < PB; i++) bwrite(b, i, pat(seed, i), 1);
  endtask

  task automatic issue(int op, bit b, int p);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_buf = b; cmd_page = 3'(p);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_page(string tag, int p);
    int bad = -1;
    logic [7:0] got = '0;
    for (int i = 0; i < PB; i++) begin
      mem_page = 3'(p); mem_addr = 4'(i); #1;
      if (mem_rdata !== m_mem[p][i] && bad < 0) begin bad = i; got = mem_rdata; end
    end
    if (bad < 0) check(tag, 0, 0);
    else check($sformatf("%s page %0d byte %0d", tag, p, bad), got, m_mem[p][bad]);
  endtask

  task automatic chk_buf(string tag, bit b);
    int bad = -1;
    logic [7:0] got = '0;
    for (int i = 0; i < PB; i++) begin
      buf_sel = b; buf_addr = 4'(i); #1;
      if (buf_rdata !== m_buf[b][i] && bad < 0) begin bad = i; got = buf_rdata; end
    end
    if (bad < 0) check(tag, 0, 0);
    else check($sformatf("%s buf %0d byte %0d", tag, b, bad), got, m_buf[b][bad]);
  endtask

  function automatic bit differs(int p, bit b);
    for (int i = 0; i < PB; i++) if (m_mem[p][i] != m_buf[b][i]) return 1;
    return 0;
  endfunction

  task automatic run(int op, bit b, int p, int len, string tag);
    exp_len_q.push_back(len); exp_tag_q.push_back(tag);
    issue(op, b, p);
    check({tag, " busy at start"}, busy, 1);
    check("R11 pull-low follows busy", pull_low, busy);
    wait_idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      check("watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit cmp_before;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 pull-low after reset", pull_low, 0);
    check("R1 err after reset", err, 0);

    // R2 program with erase
    fill(0, 1);
    run(2, 0, 4, TE, "R2 erase-program length");
    for (int i = 0; i < PB; i++) m_mem[4][i] = m_buf[0][i];
    chk_page("R2 page equals buffer", 4);

    // R3 program without erase onto written page
    fill(1, 2);
    run(3, 1, 4, TP, "R3 program length");
    for (int i = 0; i < PB; i++) m_mem[4][i] = m_mem[4][i] & m_buf[1][i];
    chk_page("R3 page is AND", 4);

    // R4 transfer into overwritten buffer
    fill(0, 3);
    run(0, 0, 4, TX, "R4 transfer length");
    for (int i = 0; i < PB; i++) m_buf[0][i] = m_mem[4][i];
    chk_buf("R4 buffer equals page", 0);

    // R5 compare: match, mismatch, single bit in last byte
    run(1, 0, 4, TX, "R5 compare length");
    check("R5 match", cmp_diff, differs(4, 0));
    run(1, 1, 4, TX, "R5 compare length");
    check("R5 mismatch", cmp_diff, differs(4, 1));
    run(1, 0, 4, TX, "R5 compare length");
    check("R5 match again", cmp_diff, 0);
    bwrite(0, PB-1, m_buf[0][PB-1] ^ 8'h01, 1);
    run(1, 0, 4, TX, "R5 compare length");
    check("R5 last-byte one-bit diff", cmp_diff, 1);

    // R7, R8: activity while busy
    fill(1, 5);
    exp_len_q.push_back(TE); exp_tag_q.push_back("R7 length unchanged by dropped cmd");
    issue(2, 1, 5);
    @(negedge clk); cmd_valid = 1; cmd_op = 3'd0; cmd_buf = 0; cmd_page = 3'd4;
    @(negedge clk); cmd_valid = 0;
    check("R7 err pulse", err, 1);
    @(negedge clk);
    check("R7 err single cycle", err, 0);
    bwrite(1, 0, 8'h5A, 0);
    bwrite(0, 3, 8'hC3, 1);
    wait_idle();
    for (int i = 0; i < PB; i++) m_mem[5][i] = m_buf[1][i];
    chk_page("R7 R8 page from untouched buffer", 5);
    chk_buf("R8 write to in-use buffer ignored", 1);
    chk_buf("R8 write to idle buffer applied", 0);
    check("R7 dropped transfer left cmp", cmp_diff, 1);

    // R9 protection
    fill(0, 6);
    run(2, 0, 1, TE, "R9 setup length");
    for (int i = 0; i < PB; i++) m_mem[1][i] = m_buf[0][i];
    fill(0, 7);
    wp_n = 0;
    issue(2, 0, 1);
    check("R9 protected erase-program no busy", busy, 0);
    issue(3, 0, 0);
    check("R9 protected program no busy", busy, 0);
    issue(4, 1, 1);
    check("R9 protected rewrite no busy", busy, 0);
    @(negedge clk);
    chk_page("R9 protected page unchanged", 1);
    run(2, 0, 6, TE, "R9 unprotected page length");
    for (int i = 0; i < PB; i++) m_mem[6][i] = m_buf[0][i];
    chk_page("R9 unprotected page written", 6);
    wp_n = 1;

    // R6 auto rewrite
    fill(1, 8);
    run(4, 1, 6, TX + TE, "R6 rewrite length");
    for (int i = 0; i < PB; i++) m_buf[1][i] = m_mem[6][i];
    chk_buf("R6 buffer loaded from page", 1);
    chk_page("R6 page rewritten", 6);

    // R10 reset abort of program and compare
    fill(0, 9);
    issue(2, 0, 2);
    repeat (3) @(negedge clk);
    rst_n = 0; #1;
    check("R10 busy drops at reset", busy, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_page("R10 aborted page unchanged", 2);
    run(1, 1, 5, TX, "R10 compare length");
    cmp_before = cmp_diff;
    check("R10 compare after reset", cmp_diff, differs(5, 1));
    issue(1, 0, 4);
    repeat (2) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 cmp kept across abort", cmp_diff, cmp_before);
    run(2, 0, 2, TE, "R10 resumes length");
    for (int i = 0; i < PB; i++) m_mem[2][i] = m_buf[0][i];
    chk_page("R10 resumes program", 2);

    check("scoreboard drained", exp_len_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule